// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block is a small fully associative table that sits beside the instruction fetch stage. Every cycle the fetch stage presents the address of the instruction it is fetching. If that address matches a stored branch, the block returns the remembered destination address in the same cycle. It also returns a taken or not-taken guess, which comes from a saturating counter kept with that entry. When nothing matches, the guess falls back to a fixed rule: a branch whose displacement points backward is guessed taken, and a forward one is guessed not taken.

The execute side reports each branch once its outcome is known. It gives the branch address, the real destination, and whether the branch was taken. An address that is already stored has its counter stepped toward the outcome and its destination replaced. An address that is not stored gains an entry only if it was taken. That entry goes into the lowest-numbered empty slot, or, when the table is full, into the slot whose last resolve is the oldest. Decode, squash and pipeline control lie outside the block.

Top module: `btb_predictor`

## Requirements
- R1: After reset no entry is valid, so every lookup reports `fetch_hit` = 0.
- R2: A lookup whose address equals the tag of a valid entry reports `fetch_hit` = 1 and that entry's stored destination on `fetch_target`, combinationally in the same cycle.
- R3: A branch misses on its first encounter. A taken resolve becomes visible to lookups from the cycle after the resolve edge, and a lookup made in the same cycle as the resolve still sees the old contents.
- R4: On a miss, `fetch_target` is zero and `fetch_taken` equals `fetch_disp_neg` (1 = backward displacement, guessed taken).
- R5: A resolve that is not taken and misses leaves the table unchanged.
- R6: A newly created entry starts its counter at the weakly-taken value, which has only the most significant bit set (binary 10 for a 2-bit counter). One not-taken resolve then turns the guess to not taken.
- R7: On a hit, `fetch_taken` is the counter's most significant bit. A resolve hit adds one when taken and subtracts one when not taken, and the counter holds at 0 and at its all-ones maximum.
- R8: A resolve hit replaces the entry's stored destination with the reported one.
- R9: A taken resolve miss fills the lowest-indexed invalid entry. When the table is full it replaces the entry whose latest resolve (hit or allocation) is the oldest.
- R10: No two valid entries ever hold the same tag. A resolve whose address is already stored never creates a second entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Address being fetched |
| fetch_disp_neg | input | 1 | Displacement sign of the fetched branch, 1 = backward |
| fetch_hit | output | 1 | Lookup matched a valid entry |
| fetch_target | output | ADDR_W | Predicted destination, zero on a miss |
| fetch_taken | output | 1 | Direction guess |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_target | input | ADDR_W | Actual destination of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench builds the block with 4 entries, 8-bit addresses and 2-bit counters. With only four slots, a pool of six branch addresses keeps the table full and forces repeated replacement. The tiny counter lets the bench drive it to both saturation limits within a few resolves. An address-driven reference model is stepped alongside the block through directed cases and a long pseudo-random sweep. It predicts which slot is replaced and what every lookup returns.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Saturating step of a w-bit direction counter.
  function automatic int unsigned sat_step(input int unsigned c, input logic up,
                                           input int unsigned w);
    int unsigned top;
    top = (32'd1 << w) - 32'd1;
    if (up) return (c >= top) ? top : c + 32'd1;
    else    return (c == 32'd0) ? 32'd0 : c - 32'd1;
  endfunction

  // Counter value given to a freshly filled entry: weakly taken.
  function automatic int unsigned weak_taken(input int unsigned w);
    return 32'd1 << (w - 32'd1);
  endfunction

  // Direction used when no entry matches: backward branches are taken.
  function automatic logic static_guess(input logic disp_neg);
    return disp_neg;
  endfunction

endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]              probe,
  output logic [ENTRIES-1:0]             match
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid[i] && (tags[i] == probe);
  end
endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   victim_idx,
  output logic [ENTRIES-1:0] oldest_vec
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0][IDX_W-1:0] age_q;
  logic [IDX_W-1:0]              touched_age;

  assign touched_age = age_q[touch_idx];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_old
    assign oldest_vec[i] = (age_q[i] == AGE_MAX);
  end

  // Ages form a permutation of 0..ENTRIES-1; the touched slot becomes 0.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)        age_q[i] <= '0;
        else if (age_q[i] < touched_age)   age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid[i] && !found) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++)
        if (oldest_vec[i]) victim_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              fetch_disp_neg,
  output logic              fetch_hit,
  output logic [ADDR_W-1:0] fetch_target,
  output logic              fetch_taken,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              res_taken
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(weak_taken(CNT_W));

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tgt_q;
  logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q;

  // Named internal events, also watched by the checker.
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] rs_match;
  logic [ENTRIES-1:0] oldest_vec;
  logic               res_hit;
  logic               upd_en;
  logic               alloc_en;
  logic               touch_en;
  logic [IDX_W-1:0]   rs_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   touch_idx;
  logic [CNT_W-1:0]   lk_cnt;
  logic [CNT_W-1:0]   rs_cnt_next;

  function automatic logic [IDX_W-1:0] encode(input logic [ENTRIES-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) if (oh[i]) r = r | IDX_W'(i);
    return r;
  endfunction

  btb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lk_match (
    .valid(valid_q), .tags(tag_q), .probe(fetch_pc), .match(lk_match));

  btb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_rs_match (
    .valid(valid_q), .tags(tag_q), .probe(res_pc), .match(rs_match));

  btb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid(valid_q), .victim_idx(victim_idx), .oldest_vec(oldest_vec));

  // Fetch side: same-cycle associative read.
  always_comb begin
    fetch_target = '0;
    lk_cnt       = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        fetch_target = fetch_target | tgt_q[i];
        lk_cnt       = lk_cnt | cnt_q[i];
      end
    end
  end

  assign fetch_hit   = |lk_match;
  assign fetch_taken = fetch_hit ? lk_cnt[CNT_W-1] : static_guess(fetch_disp_neg);

  // Resolve side.
  assign res_hit     = |rs_match;
  assign rs_idx      = encode(rs_match);
  assign upd_en      = res_valid && res_hit;
  assign alloc_en    = res_valid && res_taken && !res_hit;
  assign touch_en    = upd_en || alloc_en;
  assign touch_idx   = upd_en ? rs_idx : victim_idx;
  assign rs_cnt_next = CNT_W'(sat_step(int'(cnt_q[rs_idx]), res_taken, CNT_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      tgt_q   <= '0;
      cnt_q   <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (upd_en && rs_match[i]) begin
          cnt_q[i] <= rs_cnt_next;
          tgt_q[i] <= res_target;
        end else if (alloc_en && (victim_idx == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= res_pc;
          tgt_q[i]   <= res_target;
          cnt_q[i]   <= CNT_INIT;
        end
      end
    end
  end
endmodule

// File: rtl/btb_predictor_checker.sv
module btb_predictor_checker #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fetch_hit,
  input logic [ADDR_W-1:0]  fetch_target,
  input logic               fetch_taken,
  input logic               fetch_disp_neg,
  input logic               res_valid,
  input logic               res_taken,
  input logic               res_hit,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] rs_match,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] oldest_vec
);
  a_r10_single_lookup_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  a_r10_single_resolve_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rs_match));

  a_r10_update_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |=> $stable(valid_q));

  a_r5_nt_miss_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken && !res_hit) |=> $stable(valid_q));

  a_r3_taken_miss_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken && !res_hit) |=> (valid_q != '0));

  a_r9_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  a_r4_miss_static: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_hit |-> (fetch_taken == fetch_disp_neg && fetch_target == '0));
endmodule

bind btb_predictor btb_predictor_checker #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_hit(fetch_hit), .fetch_target(fetch_target),
  .fetch_taken(fetch_taken), .fetch_disp_neg(fetch_disp_neg),
  .res_valid(res_valid), .res_taken(res_taken), .res_hit(res_hit),
  .lk_match(lk_match), .rs_match(rs_match), .valid_q(valid_q),
  .oldest_vec(oldest_vec));

// File: tb/btb_predictor_test.sv
`timescale 1ns/1ps
module btb_predictor_test;
  localparam int AW = 8;
  localparam int NE = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          fetch_disp_neg = 1'b0;
  logic          fetch_hit;
  logic [AW-1:0] fetch_target;
  logic          fetch_taken;
  logic          res_valid = 1'b0;
  logic [AW-1:0] res_pc = '0;
  logic [AW-1:0] res_target = '0;
  logic          res_taken = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .ENTRIES(NE), .CNT_W(CW)) uut (.*);

  // Reference model.
  bit      m_v[NE];
  int      m_tag[NE];
  int      m_tgt[NE];
  int      m_cnt[NE];
  longint  m_stamp[NE];
  longint  m_time = 0;

  function automatic void m_reset();
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; m_cnt[i] = 0; m_stamp[i] = 0;
    end
  endfunction

  function automatic int m_find(input int pc);
    for (int i = 0; i < NE; i++) if (m_v[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  function automatic void m_resolve(input int pc, input int tgt, input bit tk);
    int h, v;
    h = m_find(pc);
    m_time++;
    if (h >= 0) begin
      if (tk) m_cnt[h] = (m_cnt[h] == 3) ? 3 : m_cnt[h] + 1;
      else    m_cnt[h] = (m_cnt[h] == 0) ? 0 : m_cnt[h] - 1;
      m_tgt[h] = tgt;
      m_stamp[h] = m_time;
    end else if (tk) begin
      v = -1;
      for (int i = 0; i < NE; i++) if (!m_v[i] && v < 0) v = i;
      if (v < 0) begin
        v = 0;
        for (int i = 1; i < NE; i++) if (m_stamp[i] < m_stamp[v]) v = i;
      end
      m_v[v] = 1; m_tag[v] = pc; m_tgt[v] = tgt; m_cnt[v] = 2; m_stamp[v] = m_time;
    end
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle from a negedge, check lookup before the edge, advance model.
  task automatic step(input int fpc, input bit fneg, input bit rv, input int rpc,
                      input int rtgt, input bit rtk, input string req);
    int h;
    fetch_pc = AW'(fpc); fetch_disp_neg = fneg;
    res_valid = rv; res_pc = AW'(rpc); res_target = AW'(rtgt); res_taken = rtk;
    #1;
    h = m_find(fpc);
    check(req, "hit", int'(fetch_hit), (h >= 0) ? 1 : 0);
    check(req, "target", int'(fetch_target), (h >= 0) ? m_tgt[h] : 0);
    check(req, "taken", int'(fetch_taken), (h >= 0) ? ((m_cnt[h] >> 1) & 1) : int'(fneg));
    @(posedge clk);
    if (rv) m_resolve(rpc, rtgt, rtk);
    @(negedge clk);
  endtask

  task automatic look(input int fpc, input bit fneg, input string req);
    step(fpc, fneg, 1'b0, 0, 0, 1'b0, req);
  endtask

  task automatic resolve(input int rpc, input int rtgt, input bit rtk, input string req);
    step(8'h00, 1'b0, 1'b1, rpc, rtgt, rtk, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    res_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lfsr;
    do_reset();
    // R1 / R4: empty table, static fallback both ways.
    look(8'h10, 1'b0, "R1");
    look(8'h10, 1'b1, "R4");
    look(8'hF4, 1'b0, "R4");
    // R3: same-cycle lookup misses, next cycle hits; R2 target; R6 weakly taken.
    step(8'h10, 1'b1, 1'b1, 8'h10, 8'h80, 1'b1, "R3");
    look(8'h10, 1'b0, "R2");
    check("R6", "fresh guess", int'(fetch_taken), 1);
    // R6: one not-taken flips the guess.
    resolve(8'h10, 8'h80, 1'b0, "R6");
    look(8'h10, 1'b0, "R6");
    // R7: saturate low, climb, saturate high.
    resolve(8'h10, 8'h80, 1'b0, "R7");
    resolve(8'h10, 8'h80, 1'b0, "R7");
    look(8'h10, 1'b1, "R7");
    for (int k = 0; k < 5; k++) resolve(8'h10, 8'h80, 1'b1, "R7");
    resolve(8'h10, 8'h80, 1'b0, "R7");
    look(8'h10, 1'b0, "R7");
    // R8: target overwrite on hit.
    resolve(8'h10, 8'h94, 1'b1, "R8");
    look(8'h10, 1'b0, "R8");
    // R5: not-taken miss allocates nothing.
    resolve(8'h20, 8'h30, 1'b0, "R5");
    look(8'h20, 1'b1, "R5");
    // R9: fill, touch, then evict least recent.
    resolve(8'h24, 8'h44, 1'b1, "R9");
    resolve(8'h28, 8'h48, 1'b1, "R9");
    resolve(8'h2C, 8'h4C, 1'b1, "R9");
    resolve(8'h10, 8'h94, 1'b1, "R9");
    resolve(8'h34, 8'h54, 1'b1, "R9");
    look(8'h24, 1'b0, "R9");
    look(8'h10, 1'b0, "R9");
    look(8'h34, 1'b0, "R9");
    // R10: repeated resolves of a stored address never duplicate it.
    for (int k = 0; k < 6; k++) resolve(8'h28, 8'h60 + k, 1'b1, "R10");
    resolve(8'h38, 8'h58, 1'b1, "R10");
    resolve(8'h3C, 8'h5C, 1'b1, "R10");
    look(8'h28, 1'b0, "R10");
    look(8'h2C, 1'b0, "R10");
    // Sweep over a six-address pool with concurrent lookup and resolve.
    do_reset();
    look(8'h40, 1'b1, "R1");
    lfsr = 32'h1ACE;
    for (int n = 0; n < 3000; n++) begin
      int fa, ra;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      fa = 8'h40 + 4 * ((lfsr & 32'hFF) % 6);
      ra = 8'h40 + 4 * (((lfsr >> 8) & 32'hFF) % 6);
      step(fa, lfsr[3], lfsr[4] | lfsr[5], ra, (lfsr >> 6) & 32'hFF,
           lfsr[9] | lfsr[10], "R9");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule